// File: doc/BRIEF.md
# Byte-Swap and Sign-Extend Unit

This combinational unit serves a 64-bit register machine. It takes one instruction word and the value of the register named by the instruction's rt field. It decodes the word and returns a 64-bit result, the index of the destination register, a write strobe and a reserved-instruction flag. All operations share one opcode. Two function codes split them into a 32-bit group and a 64-bit group. Inside each group, the 5-bit shift-amount field chooses the operation.

The 32-bit group has three operations. The first swaps the bytes inside each low halfword. The other two sign-extend a byte or a halfword. Every 32-bit result is sign-extended from bit 31 across the whole 64-bit register. The 64-bit group swaps the bytes inside all four halfwords, or reverses the order of the four halfwords. The 64-bit group works only when a 64-bit-mode input is high. The register file and pipeline control are outside the unit. The unit only reports what should be written and where.

Top module: `bsx_unit`

## Requirements
- R1: The unit claims an instruction when bits [31:26] equal 011111 and bits [5:0] equal 100000 (32-bit group) or 100100 (64-bit group). For any other word, `wrEn` and `resvInstr` are 0 and `result` is 0.
- R2: In the 32-bit group, selector [10:6] = 00010 swaps the two bytes inside each of the halfwords [15:0] and [31:16]. It then copies bit 31 of the swapped value into bits [63:32].
- R3: In the 32-bit group, selector 10000 returns rt[7:0] sign-extended to 64 bits.
- R4: In the 32-bit group, selector 11000 returns rt[15:0] sign-extended to 64 bits.
- R5: In the 64-bit group, selector 00010 swaps the two bytes inside each of the four halfwords of rt.
- R6: In the 64-bit group, selector 00101 reverses the four halfwords. rt[63:48] goes to [15:0], rt[47:32] to [31:16], rt[31:16] to [47:32], and rt[15:0] to [63:48].
- R7: A claimed 64-bit-group word with `mode64` low raises `resvInstr`, holds `wrEn` at 0 and gives `result` 0.
- R8: A claimed word whose rs field [25:21] is non-zero, or whose selector is not listed for its group, raises `resvInstr`, holds `wrEn` at 0 and gives `result` 0.
- R9: `rdIdx` always equals bits [15:11] of the instruction. `wrEn` and `resvInstr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rtVal | input | 64 | Value of the rt source register |
| mode64 | input | 1 | Enables the 64-bit operation group |
| result | output | 64 | Value to write to the destination |
| rdIdx | output | 5 | Destination register index |
| wrEn | output | 1 | Result is valid and should be written |
| resvInstr | output | 1 | Claimed word is illegal here |

## Verification
The hardest cases are sign bits that sit where the operation moves them. For the 32-bit byte swap, bit 31 of the result comes from rt bit 23, not from bit 31. Operands where these two bits differ show whether the extension is taken after the swap. For the 64-bit forms, the hard case is a legal encoding that is blocked only by a low `mode64`. The stimulus therefore sends every encoding under both mode settings. It also sends walking-one and sign-boundary operands alongside random ones. It flips the rs field and every selector value, so that each decode path is exercised.

// File: rtl/bsx_pkg.sv
package bsx_pkg;
  localparam int DATA_W  = 64;
  localparam int HALF_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int N_HALF  = DATA_W / HALF_W;
  localparam int REG_IDX_W = 5;

  localparam logic [5:0] OPC_SPECIAL = 6'b011111;
  localparam logic [5:0] FN_GRP32    = 6'b100000;
  localparam logic [5:0] FN_GRP64    = 6'b100100;
  localparam logic [4:0] SEL_BSWAP   = 5'b00010;
  localparam logic [4:0] SEL_SEXTB   = 5'b10000;
  localparam logic [4:0] SEL_SEXTH   = 5'b11000;
  localparam logic [4:0] SEL_HREV    = 5'b00101;

  typedef struct packed {
    logic swapB32;
    logic sextB;
    logic sextH;
    logic swapB64;
    logic revH;
  } bsxStrobe_t;
endpackage

// File: rtl/bsx_ctrl.sv
module bsx_ctrl
  import bsx_pkg::*;
(
  input  logic [31:0]          instr,
  input  logic                 mode64,
  output bsxStrobe_t           strobe,
  output logic [REG_IDX_W-1:0] rdIdx,
  output logic                 wrEn,
  output logic                 resvInstr
);
  logic opMatch, grp32, grp64, claimed, rsZero;
  logic [4:0] sel;

  assign opMatch = (instr[31:26] == OPC_SPECIAL);
  assign grp32   = opMatch && (instr[5:0] == FN_GRP32);
  assign grp64   = opMatch && (instr[5:0] == FN_GRP64);
  assign claimed = grp32 || grp64;
  assign rsZero  = (instr[25:21] == 5'd0);
  assign sel     = instr[10:6];
  assign rdIdx   = instr[15:11];

  always_comb begin
    strobe = '0;
    if (rsZero) begin
      if (grp32) begin
        case (sel)
          SEL_BSWAP: strobe.swapB32 = 1'b1;
          SEL_SEXTB: strobe.sextB   = 1'b1;
          SEL_SEXTH: strobe.sextH   = 1'b1;
          default:   strobe = '0;
        endcase
      end else if (grp64 && mode64) begin
        case (sel)
          SEL_BSWAP: strobe.swapB64 = 1'b1;
          SEL_HREV:  strobe.revH    = 1'b1;
          default:   strobe = '0;
        endcase
      end
    end
  end

  assign wrEn      = |strobe;
  assign resvInstr = claimed && !wrEn;

  always_comb begin
    a_r9_onehot_strobe: assert ($onehot0(strobe));
    a_r9_no_write_and_resv: assert (!(wrEn && resvInstr));
    if (grp64 && !mode64) a_r7_mode_block: assert (!wrEn && resvInstr);
    if (!claimed) a_r1_unclaimed_quiet: assert (!wrEn && !resvInstr);
  end
endmodule

// File: rtl/bsx_datapath.sv
module bsx_datapath
  import bsx_pkg::*;
(
  input  logic [DATA_W-1:0] rtVal,
  input  bsxStrobe_t        strobe,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] byteSwapped;
  logic [DATA_W-1:0] halfReversed;
  logic [WORD_W-1:0] lowSwapped;

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign byteSwapped[h*HALF_W +: HALF_W] =
      {rtVal[h*HALF_W +: BYTE_W], rtVal[h*HALF_W+BYTE_W +: BYTE_W]};
    assign halfReversed[h*HALF_W +: HALF_W] =
      rtVal[(N_HALF-1-h)*HALF_W +: HALF_W];
  end

  assign lowSwapped = byteSwapped[WORD_W-1:0];

  always_comb begin
    result = '0;
    if (strobe.swapB32)
      result = {{(DATA_W-WORD_W){lowSwapped[WORD_W-1]}}, lowSwapped};
    else if (strobe.sextB)
      result = {{(DATA_W-BYTE_W){rtVal[BYTE_W-1]}}, rtVal[BYTE_W-1:0]};
    else if (strobe.sextH)
      result = {{(DATA_W-HALF_W){rtVal[HALF_W-1]}}, rtVal[HALF_W-1:0]};
    else if (strobe.swapB64)
      result = byteSwapped;
    else if (strobe.revH)
      result = halfReversed;
  end

  always_comb begin
    if (strobe.swapB32 || strobe.sextB || strobe.sextH)
      a_r2_upper_is_extension: assert (result[DATA_W-1:WORD_W-1] == '0 ||
                                       result[DATA_W-1:WORD_W-1] == '1);
    if (strobe.swapB32) a_r2_sign_source: assert (result[WORD_W-1] == rtVal[23]);
    if (strobe.revH) a_r6_top_half: assert (result[DATA_W-1 -: HALF_W] == rtVal[HALF_W-1:0]);
    if (!(|strobe)) a_r8_zero_when_idle: assert (result == '0);
  end
endmodule

// File: rtl/bsx_unit.sv
module bsx_unit
  import bsx_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [63:0] rtVal,
  input  logic        mode64,
  output logic [63:0] result,
  output logic [4:0]  rdIdx,
  output logic        wrEn,
  output logic        resvInstr
);
  bsxStrobe_t strobe;

  bsx_ctrl u_ctrl (
    .instr(instr), .mode64(mode64), .strobe(strobe),
    .rdIdx(rdIdx), .wrEn(wrEn), .resvInstr(resvInstr)
  );

  bsx_datapath u_dp (
    .rtVal(rtVal), .strobe(strobe), .result(result)
  );
endmodule

// File: tb/sim_bsx_unit.sv
module sim_bsx_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] instr = '0;
  logic [63:0] rtVal = '0;
  logic mode64 = 1'b0;
  logic [63:0] result;
  logic [4:0] rdIdx;
  logic wrEn, resvInstr;
  int nChecks = 0;
  int nFails = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  bsx_unit u0 (.instr(instr), .rtVal(rtVal), .mode64(mode64), .result(result),
               .rdIdx(rdIdx), .wrEn(wrEn), .resvInstr(resvInstr));

  function automatic logic [31:0] mkInstr(input logic [5:0] opc, input logic [4:0] rs,
      input logic [4:0] rt, input logic [4:0] rd, input logic [4:0] sel, input logic [5:0] fn);
    return {opc, rs, rt, rd, sel, fn};
  endfunction

  // behavioural model from the requirements
  function automatic void refModel(input logic [31:0] ins, input logic [63:0] v,
      input logic m64, output logic [63:0] res, output logic we, output logic rv);
    logic [31:0] w;
    logic claimed;
    claimed = ins[31:26] == 6'h1f && (ins[5:0] == 6'h20 || ins[5:0] == 6'h24);
    res = 64'd0; we = 1'b0; rv = claimed;
    if (claimed && ins[25:21] == 5'd0) begin
      if (ins[5:0] == 6'h20) begin
        case (ins[10:6])
          5'd2: begin
            w = {v[23:16], v[31:24], v[7:0], v[15:8]};
            res = {{32{w[31]}}, w}; we = 1'b1;
          end
          5'd16: begin res = 64'($signed(v[7:0])); we = 1'b1; end
          5'd24: begin res = 64'($signed(v[15:0])); we = 1'b1; end
          default: ;
        endcase
      end else if (m64) begin
        if (ins[10:6] == 5'd2) begin
          for (int i = 0; i < 8; i += 2) begin
            res[i*8 +: 8] = v[(i+1)*8 +: 8];
            res[(i+1)*8 +: 8] = v[i*8 +: 8];
          end
          we = 1'b1;
        end else if (ins[10:6] == 5'd5) begin
          res = {v[15:0], v[31:16], v[47:32], v[63:48]}; we = 1'b1;
        end
      end
    end
    if (we) rv = 1'b0;
  endfunction

  task automatic applyCheck(input logic [31:0] ins, input logic [63:0] v,
                            input logic m64, input string tag);
    logic [63:0] eRes;
    logic eWe, eRv;
    @(posedge clk); #1;
    instr = ins; rtVal = v; mode64 = m64;
    refModel(ins, v, m64, eRes, eWe, eRv);
    @(negedge clk);
    nChecks++;
    if (result !== eRes || wrEn !== eWe || resvInstr !== eRv || rdIdx !== ins[15:11]) begin
      nFails++;
      $display("FAIL %s instr=%h rt=%h m64=%b: got res=%h we=%b rv=%b rd=%0d exp res=%h we=%b rv=%b rd=%0d",
               tag, ins, v, m64, result, wrEn, resvInstr, rdIdx, eRes, eWe, eRv, ins[15:11]);
    end
  endtask

  function automatic string tagFor(input logic [5:0] fn, input logic [4:0] sel);
    if (fn == 6'h20 && sel == 5'd2) return "R2";
    if (fn == 6'h20 && sel == 5'd16) return "R3";
    if (fn == 6'h20 && sel == 5'd24) return "R4";
    if (fn == 6'h24 && sel == 5'd2) return "R5";
    if (fn == 6'h24 && sel == 5'd5) return "R6";
    return "R8";
  endfunction

  initial begin
    logic [63:0] pats [0:9];
    pats[0] = 64'h0; pats[1] = '1; pats[2] = 64'h80; pats[3] = 64'h7f;
    pats[4] = 64'h8000; pats[5] = 64'h8000_0000; pats[6] = 64'h0080_0000;
    pats[7] = 64'h0123_4567_89ab_cdef; pats[8] = 64'h7fff_ffff_ff7f_ff00;
    pats[9] = 64'h8000_0000_0000_0001;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R1 idle word / reset state
    applyCheck(32'h0, 64'hdead_beef_0000_0001, 1'b1, "R1 idle");
    // main operations, both modes, boundary operands
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 10; p++) begin
        applyCheck(mkInstr(6'h1f, 0, 5'd3, 5'd7, 5'd2, 6'h20), pats[p], m[0], "R2");
        applyCheck(mkInstr(6'h1f, 0, 5'd3, 5'd8, 5'd16, 6'h20), pats[p], m[0], "R3");
        applyCheck(mkInstr(6'h1f, 0, 5'd3, 5'd9, 5'd24, 6'h20), pats[p], m[0], "R4");
        applyCheck(mkInstr(6'h1f, 0, 5'd3, 5'd10, 5'd2, 6'h24), pats[p], m[0], m[0] ? "R5" : "R7");
        applyCheck(mkInstr(6'h1f, 0, 5'd3, 5'd31, 5'd5, 6'h24), pats[p], m[0], m[0] ? "R6" : "R7");
      end
    end
    // walking ones through every selector value, both groups
    for (int s = 0; s < 32; s++) begin
      applyCheck(mkInstr(6'h1f, 0, 5'd1, 5'(s), 5'(s), 6'h20), 64'd1 << (s*2), 1'b1,
                 tagFor(6'h20, 5'(s)));
      applyCheck(mkInstr(6'h1f, 0, 5'd1, 5'(s), 5'(s), 6'h24), 64'd1 << (s*2+1), 1'b1,
                 tagFor(6'h24, 5'(s)));
    end
    // R8 non-zero rs field
    for (int r = 1; r < 32; r += 5) begin
      applyCheck(mkInstr(6'h1f, 5'(r), 5'd2, 5'd4, 5'd2, 6'h20), 64'h1234_5678_9abc_def0, 1'b1, "R8 rs");
      applyCheck(mkInstr(6'h1f, 5'(r), 5'd2, 5'd4, 5'd5, 6'h24), 64'h1234_5678_9abc_def0, 1'b1, "R8 rs");
    end
    // R1 wrong opcode or function
    applyCheck(mkInstr(6'h1e, 0, 5'd2, 5'd4, 5'd2, 6'h20), 64'hffff_0000_ffff_0000, 1'b1, "R1 opc");
    applyCheck(mkInstr(6'h1f, 0, 5'd2, 5'd4, 5'd2, 6'h21), 64'hffff_0000_ffff_0000, 1'b1, "R1 fn");
    applyCheck(mkInstr(6'h1f, 0, 5'd2, 5'd4, 5'd5, 6'h00), 64'hffff_0000_ffff_0000, 1'b1, "R1 fn");
    // random operands and words (R9 rdIdx tracking included in every check)
    for (int k = 0; k < 400; k++) begin
      logic [4:0] sel;
      logic [5:0] fn;
      logic [4:0] rs;
      sel = ($urandom % 4 == 0) ? 5'($urandom) : (($urandom % 2) ? 5'd2 : (($urandom % 2) ? 5'd5 : 5'd24));
      if ($urandom % 5 == 0) sel = 5'd16;
      fn = ($urandom % 2) ? 6'h20 : 6'h24;
      rs = ($urandom % 8 == 0) ? 5'($urandom) : 5'd0;
      applyCheck(mkInstr(6'h1f, rs, 5'($urandom), 5'($urandom), sel, fn),
                 {$urandom, $urandom}, 1'($urandom), "R9 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog expired: got running expected finished");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule